// File: doc/BRIEF.md
# Two-Way Set-Associative Lookup Cache

This block is the lookup and placement core of a small cache. Each block holds one 32-bit word. A request address is split into three fields. The two lowest bits select a byte within the word, and the cache ignores them. The next bits form the set index, which is the word address modulo the number of sets. The remaining upper bits form the tag. Both ways of the selected set are compared against the tag at once. The one-hot compare result steers an AND-OR multiplexer that returns the matching word.

The surrounding logic sends a lookup on the request port and receives hit, miss and data one cycle later. After a miss it supplies the missing word on the refill port. A refill lands in the following place:
- the way that already holds that tag, if there is one;
- otherwise the first invalid way;
- otherwise the way named by the set's single least-recently-used bit.

Two addresses that share a set can therefore stay resident together.

Top module: `cache2w_top`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and every LRU bit, and leaves the response port idle. The first lookup after reset misses.
- R2: Each request accepted in a cycle gives exactly one response (`rsp_valid` high) in the next cycle. Requests may be issued on back-to-back cycles. No response appears without a request.
- R3: The set index is address bits [IDX_W+1:2]. The tag is bits [ADDR_W-1:IDX_W+2]. Bits [1:0] take no part in lookup or refill.
- R4: A hit returns the stored word with `rsp_hit`=1 and `rsp_miss`=0. A miss returns `rsp_miss`=1, `rsp_hit`=0 and data 0. Exactly one of the two is high during a response.
- R5: A way whose valid bit is clear never produces a match.
- R6: A refill into a set that has an invalid way writes the lowest-numbered invalid way. A word just refilled hits on a lookup in the next cycle.
- R7: When both ways are valid, a refill of a new tag replaces the way named by the set's LRU bit. The LRU bit identifies the way to evict: 0 means way 0, 1 means way 1. Every hit and every refill sets that bit to the other way.
- R8: A refill whose tag is already resident in the set overwrites that way in place. The other way is left untouched.
- R9: Starting empty, eight alternating accesses to two word addresses in the same set, each miss followed by a refill, give exactly 2 misses.
- R10: A lookup in the same cycle as a refill sees the set contents from before that refill. If both update the same set's LRU bit, the refill's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Byte address to look up |
| fill_valid | input | 1 | Refill write strobe |
| fill_addr | input | ADDR_W | Byte address of the refilled word |
| fill_data | input | 32 | Refilled word |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Response is a hit |
| rsp_miss | output | 1 | Response is a miss |
| rsp_data | output | 32 | Returned word on a hit, 0 on a miss |

## Verification
Every lookup result is due exactly one clock edge after the request is sampled. A refill becomes visible to a lookup sampled one edge after the refill. The bench drives inputs on falling edges. The driver queues the expected hit and data at the moment it issues a request, and the monitor pops and compares on the next falling edge, when the registered response has been stable for half a period. Replacement order is checked by a sequence of refills and lookups whose expected victims are derived from the LRU rule. The scoreboard catches any response that arrives late, early or unrequested.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int WAYS   = 2;
    localparam int OFF_W  = 2;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Encoded result of a parallel tag compare
    typedef struct packed {
        logic hit;
        logic way;
    } probe_t;

    function automatic probe_t encode_match(input logic [WAYS-1:0] m);
        probe_t p;
        p.hit = |m;
        p.way = m[1];
        return p;
    endfunction

    // Invalid ways are filled lowest first; only a full set consults LRU
    function automatic logic pick_victim(input logic [WAYS-1:0] vld, input logic lru);
        logic v;
        if (!vld[0])      v = 1'b0;
        else if (!vld[1]) v = 1'b1;
        else              v = lru;
        return v;
    endfunction

endpackage

// File: rtl/cache2w_tagcmp.sv
module cache2w_tagcmp
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 27
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic [WAYS-1:0]             match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == key);
    end
endmodule

// File: rtl/cache2w_waymux.sv
module cache2w_waymux
    import cache2w_pkg::*;
(
    input  logic [WAYS-1:0]              sel,
    input  logic [WAYS-1:0][WORD_W-1:0]  words,
    output word_t                        out
);
    always_comb begin
        out = '0;
        for (int w = 0; w < WAYS; w++) begin
            out = out | (words[w] & {WORD_W{sel[w]}});
        end
    end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_set,
    input  logic             hit_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic             rd_lru
);
    logic [SETS-1:0] evict_q;

    assign rd_lru = evict_q[rd_set];

    // Refill update is written last so it overrides a hit on the same set
    always_ff @(posedge clk) begin
        if (rst) begin
            evict_q <= '0;
        end else begin
            if (hit_en)  evict_q[hit_set]  <= ~hit_way;
            if (fill_en) evict_q[fill_set] <= ~fill_way;
        end
    end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [31:0]       fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [31:0]       rsp_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    // Storage
    logic [WAYS-1:0][SETS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q  [WAYS][SETS];
    word_t                     data_q [WAYS][SETS];

    // Address fields
    logic [IDX_W-1:0] q_idx, f_idx;
    logic [TAG_W-1:0] q_tag, f_tag;
    assign q_idx = req_addr[OFF_W +: IDX_W];
    assign q_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign f_idx = fill_addr[OFF_W +: IDX_W];
    assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

    // Per-way read-out for the lookup set and the refill set
    logic [WAYS-1:0]              q_vld, f_vld;
    logic [WAYS-1:0][TAG_W-1:0]   q_tags, f_tags;
    logic [WAYS-1:0][WORD_W-1:0]  q_words;

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign q_vld[w]   = vld_q[w][q_idx];
        assign q_tags[w]  = tag_q[w][q_idx];
        assign q_words[w] = data_q[w][q_idx];
        assign f_vld[w]   = vld_q[w][f_idx];
        assign f_tags[w]  = tag_q[w][f_idx];
    end

    logic [WAYS-1:0] q_match, f_match;

    cache2w_tagcmp #(.TAG_W(TAG_W)) u_qcmp (
        .vld   (q_vld),
        .tags  (q_tags),
        .key   (q_tag),
        .match (q_match)
    );

    cache2w_tagcmp #(.TAG_W(TAG_W)) u_fcmp (
        .vld   (f_vld),
        .tags  (f_tags),
        .key   (f_tag),
        .match (f_match)
    );

    word_t q_word;

    cache2w_waymux u_mux (
        .sel   (q_match),
        .words (q_words),
        .out   (q_word)
    );

    probe_t q_probe, f_probe;
    assign q_probe = encode_match(q_match);
    assign f_probe = encode_match(f_match);

    logic f_lru;
    logic f_way;
    assign f_way = f_probe.hit ? f_probe.way : pick_victim(f_vld, f_lru);

    logic q_hit;
    assign q_hit = req_valid && q_probe.hit;

    cache2w_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .hit_en   (q_hit),
        .hit_set  (q_idx),
        .hit_way  (q_probe.way),
        .fill_en  (fill_valid),
        .fill_set (f_idx),
        .fill_way (f_way),
        .rd_set   (f_idx),
        .rd_lru   (f_lru)
    );

    // Valid bits
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (fill_valid) begin
            vld_q[f_way][f_idx] <= 1'b1;
        end
    end

    // Tag and data arrays (no reset needed: guarded by valid)
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            tag_q[f_way][f_idx]  <= f_tag;
            data_q[f_way][f_idx] <= fill_data;
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= q_hit;
            rsp_data  <= q_hit ? q_word : '0;
        end
    end

    assign rsp_miss = rsp_valid && !rsp_hit;

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [31:0]       rsp_data
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    p_req_gives_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    p_quiet_flags_r4: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    p_miss_data_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_data == 32'd0));

    p_fill_then_hit_r6: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> ((req_valid && req_addr[ADDR_W-1:2] == $past(fill_addr[ADDR_W-1:2]))
                        |=> rsp_hit));
endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_data   (rsp_data)
);

// File: tb/cache2w_top_bench.sv
`timescale 1ns/1ps
module cache2w_top_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [31:0]   fill_data = '0;
    logic          rsp_valid, rsp_hit, rsp_miss;
    logic [31:0]   rsp_data;

    always #2 clk = ~clk;

    cache2w_top #(.ADDR_W(AW), .SETS(4)) u_cache2w_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_data(rsp_data)
    );

    typedef struct {
        logic        hit;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_err    = 0;
    int   n_miss   = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dv(input logic [AW-1:0] a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (rsp_miss) n_miss++;
            if (q.size() == 0) begin
                check(0, "R2", "unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_hit == e.hit, e.req, "hit", 32'(rsp_hit), 32'(e.hit));
                check(rsp_miss == !e.hit, e.req, "miss", 32'(rsp_miss), 32'(!e.hit));
                check(rsp_data == (e.hit ? e.data : 32'd0), e.req, "data",
                      rsp_data, e.hit ? e.data : 32'd0);
            end
        end
    end

    // Driver tasks: called on a falling edge, return on the next one
    task automatic lookup(input logic [AW-1:0] a, input logic h,
                          input logic [31:0] d, input string req);
        exp_t e;
        req_valid = 1'b1;
        req_addr  = a;
        e.hit = h; e.data = d; e.req = req;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [AW-1:0] a, input logic [31:0] d);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_data  = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic both(input logic [AW-1:0] ra, input logic h, input logic [31:0] d,
                        input logic [AW-1:0] fa, input logic [31:0] fd, input string req);
        exp_t e;
        req_valid = 1'b1; req_addr = ra;
        fill_valid = 1'b1; fill_addr = fa; fill_data = fd;
        e.hit = h; e.data = d; e.req = req;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(0, "R2", "watchdog expired", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int m0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(rsp_hit == 1'b0,   "R1", "rsp_hit after reset",   32'(rsp_hit),   32'd0);
        // R1/R5: empty cache misses
        lookup(16'h0000, 0, 0, "R1");
        // R3/R4: refill then hit with a different byte offset
        fill(16'h0000, dv(16'h0000));
        lookup(16'h0003, 1, dv(16'h0000), "R3");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", "no response when idle", 32'(rsp_valid), 32'd0);

        // R9: ping-pong between words 1 and 5 (both set 1)
        m0 = n_miss;
        lookup(16'h0004, 0, 0, "R9");
        fill(16'h0004, dv(16'h0004));
        lookup(16'h0014, 0, 0, "R9");
        fill(16'h0014, dv(16'h0014));
        for (int i = 0; i < 3; i++) begin
            lookup(16'h0004, 1, dv(16'h0004), "R9");
            lookup(16'h0014, 1, dv(16'h0014), "R9");
        end
        @(negedge clk);
        check(n_miss - m0 == 2, "R9", "miss count", 32'(n_miss - m0), 32'd2);

        // R7: LRU replacement in full set 1 (evict bit now names way 0)
        fill(16'h0025, dv(16'h0024));                 // R3 offset ignored on refill
        lookup(16'h0004, 0, 0, "R7");
        lookup(16'h0024, 1, dv(16'h0024), "R7");      // hit way0 -> evict way1
        lookup(16'h0014, 1, dv(16'h0014), "R7");      // hit way1 -> evict way0
        fill(16'h0034, dv(16'h0034));                 // replaces 0x24
        lookup(16'h0014, 1, dv(16'h0014), "R7");
        lookup(16'h0024, 0, 0, "R7");
        lookup(16'h0034, 1, dv(16'h0034), "R7");

        // R8: refill of resident tag overwrites in place (set 2)
        fill(16'h0008, 32'h1111_0008);
        fill(16'h0008, 32'h2222_0008);
        fill(16'h0018, dv(16'h0018));
        lookup(16'h0008, 1, 32'h2222_0008, "R8");
        lookup(16'h0018, 1, dv(16'h0018), "R8");
        fill(16'h0028, dv(16'h0028));                 // evicts 0x08
        lookup(16'h0018, 1, dv(16'h0018), "R8");
        lookup(16'h0008, 0, 0, "R8");
        lookup(16'h0028, 1, dv(16'h0028), "R8");

        // R6: invalid way filled before eviction (set 3)
        fill(16'h000C, dv(16'h000C));
        fill(16'h001C, dv(16'h001C));
        lookup(16'h000C, 1, dv(16'h000C), "R6");
        lookup(16'h001C, 1, dv(16'h001C), "R6");

        // R10: same-cycle lookup sees pre-refill contents (set 0)
        both(16'h0010, 0, 0, 16'h0010, dv(16'h0010), "R10");
        lookup(16'h0010, 1, dv(16'h0010), "R10");
        lookup(16'h0000, 1, dv(16'h0000), "R10");     // evict bit -> way1
        // hit way0 and refill into way1 together: refill sets evict bit to way0
        both(16'h0000, 1, dv(16'h0000), 16'h0020, dv(16'h0020), "R10");
        fill(16'h0030, dv(16'h0030));                 // must evict 0x00 in way0

        // R2: back-to-back requests
        req_valid = 1'b1;
        begin
            logic [AW-1:0] ad [4];
            logic          hh [4];
            ad[0] = 16'h0020; hh[0] = 1;
            ad[1] = 16'h0030; hh[1] = 1;
            ad[2] = 16'h0000; hh[2] = 0;
            ad[3] = 16'h0010; hh[3] = 0;
            for (int i = 0; i < 4; i++) begin
                exp_t e;
                req_addr = ad[i];
                e.hit = hh[i]; e.data = hh[i] ? dv(ad[i]) : 32'd0; e.req = "R10";
                q.push_back(e);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, "R2", "responses outstanding", 32'(q.size()), 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule